// File: doc/BRIEF.md
# Clock-Master Synchronous Serial Byte Receiver

This block is the receive side of a serial channel running in synchronous mode, with the channel acting as clock master. Software arms it by pulsing a receive-start strobe. The block then drives a shift clock on its clock pin and samples the incoming data line once per shift-clock period. Bits arrive least significant first. Once a full byte is in, the block copies it into a receive buffer, raises a sticky receive-complete flag, drops its armed bit and stops the clock. Every byte needs a fresh start.

The bit rate comes from a baud-tick clock-enable input. One shift-clock period spans two ticks: the first tick pulls the clock low, and the second raises it and samples the data line. Software may disarm the receiver during a byte, and that byte still runs to completion. The receive buffer carries an "unread" marker, which the buffer-read strobe clears. If overrun checking is on and a byte completes while the previous one is still unread, both an overrun flag and an error request flag are raised. The new byte is stored either way.

A write to the transmit buffer is refused while a byte is being received. When the receiver is idle, the same write produces a one-cycle transmit-start pulse.

Top module: `srx_sync_rx`

## Requirements
- R1: After reset, `sclk_o` is 1, and `ren`, `rir`, `eir`, `oe` and `tx_start` are 0. `rx_buf` is 0.
- R2: A `ren_set` pulse while idle sets `ren` and starts a byte. `sclk_o` rests at 1. The first baud tick after the start drives it to 0, and the next tick drives it back to 1. While idle it never toggles.
- R3: Data is sampled on the tick that raises `sclk_o`. The first sampled bit lands in `rx_buf[0]` and the eighth in `rx_buf[7]`. `rx_buf` changes only when a byte completes.
- R4: On the eighth sample, the new byte appears in `rx_buf` and `rir` becomes 1 in the next cycle. In the same cycle `ren` falls to 0 and the shift clock stops at 1.
- R5: `ren_clr` during a byte clears `ren`, but the byte still completes and still sets `rir`.
- R6: `tbuf_wr` while idle, and not in the same cycle as `ren_set`, gives `tx_start` = 1 for exactly the next cycle. `tbuf_wr` during a byte, or together with a starting `ren_set`, gives no pulse and leaves the byte unchanged.
- R7: When a byte completes while the previous one is unread, no `buf_rd` occurs in that cycle, and `oe_chk_en` = 1, both `oe` and `eir` are set. The new byte overwrites `rx_buf`. With `oe_chk_en` = 0, neither flag is set.
- R8: A `buf_rd` in the same cycle as a byte's completion counts as reading the old byte, so no overrun results.
- R9: `rir`, `eir` and `oe` are sticky. They are cleared by `flag_clr` bits 0, 1 and 2 respectively. If a flag is set and cleared in the same cycle, it ends up set.
- R10: `ren_set` during a byte neither restarts nor lengthens that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Bit-rate clock enable, two per shift-clock period |
| ren_set | input | 1 | Strobe: arm the receiver |
| ren_clr | input | 1 | Strobe: disarm the receiver |
| oe_chk_en | input | 1 | Overrun check enable (level) |
| buf_rd | input | 1 | Strobe: receive buffer has been read |
| tbuf_wr | input | 1 | Strobe: write to the transmit buffer |
| flag_clr | input | 3 | Write-one-to-clear: bit0 rir, bit1 eir, bit2 oe |
| rxd_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Shift clock out, idles high |
| rx_buf | output | DATA_W | Receive buffer |
| ren | output | 1 | Receiver armed bit |
| rir | output | 1 | Receive-complete request flag |
| eir | output | 1 | Error request flag |
| oe | output | 1 | Overrun status flag |
| tx_start | output | 1 | One-cycle transmit start pulse |

## Verification
Two pairs of events can land on the same edge: the eighth sample with a buffer read strobe, and the eighth sample with a flag clear strobe. The bench watches its reference model for the edge on which the eighth sample will land and raises `buf_rd` or `flag_clr` for exactly that cycle. A correct design shows no overrun in the first case and keeps `rir` set in the second. Both are judged by the per-cycle comparison against the model and by explicit checks on the flags afterward.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FL_RIR = 0;
  localparam int unsigned FL_EIR = 1;
  localparam int unsigned FL_OE  = 2;

  // shift a word right by one, new bit entering at position w-1
  function automatic logic [31:0] shift_lsb_first(input logic [31:0] sr,
                                                   input logic b,
                                                   input int unsigned w);
    logic [31:0] r;
    r = sr >> 1;
    r[w-1] = b;
    return r;
  endfunction

  // overrun: old word unread, not read now, and the check enabled
  function automatic logic overrun_hit(input logic unread,
                                       input logic rd_now,
                                       input logic chk_en);
    return unread & ~rd_now & chk_en;
  endfunction

endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  input  logic baud_tick,
  output logic sclk,
  output logic sample
);
  logic phase_q;
  logic tick_live;

  assign tick_live = busy & baud_tick;
  assign sample    = tick_live & phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      sclk    <= 1'b1;
    end else if (start) begin
      phase_q <= 1'b0;
      sclk    <= 1'b1;
    end else if (tick_live) begin
      phase_q <= ~phase_q;
      sclk    <= phase_q;
    end
  end

  assert_sclk_low_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> busy);
  assert_rise_samples_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(sample));
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sample,
  input  logic              rxd,
  output logic              byte_done,
  output logic [DATA_W-1:0] next_word
);
  import srx_pkg::*;
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       wide;

  assign wide      = shift_lsb_first(32'(sr_q), rxd, DATA_W);
  assign next_word = wide[DATA_W-1:0];
  assign byte_done = sample & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (sample) begin
      sr_q  <= next_word;
      cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (cnt_q == '0));
endmodule

// File: rtl/srx_flags.sv
module srx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] next_word,
  input  logic              buf_rd,
  input  logic              oe_chk_en,
  input  logic [2:0]        flag_clr,
  output logic [DATA_W-1:0] rx_buf,
  output logic [2:0]        flags
);
  import srx_pkg::*;
  logic             unread_q;
  logic             ovr_ev;
  logic [FLAG_N-1:0] set_vec;

  assign ovr_ev  = byte_done & overrun_hit(unread_q, buf_rd, oe_chk_en);
  assign set_vec = {ovr_ev, ovr_ev, byte_done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf   <= '0;
      unread_q <= 1'b0;
    end else if (byte_done) begin
      rx_buf   <= next_word;
      unread_q <= 1'b1;
    end else if (buf_rd) begin
      unread_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (flag_clr[i]) flags[i] <= 1'b0;
    end
  end

  assert_rir_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> flags[FL_RIR]);
  assert_oe_with_eir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_OE] && !$past(flags[FL_OE])) |-> flags[FL_EIR]);
  assert_buf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rx_buf));
  assert_read_no_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && buf_rd && !flags[FL_OE]) |=> !flags[FL_OE]);
  assert_clear_loses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && flag_clr[FL_RIR]) |=> flags[FL_RIR]);
endmodule

// File: rtl/srx_sync_rx.sv
module srx_sync_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              ren_set,
  input  logic              ren_clr,
  input  logic              oe_chk_en,
  input  logic              buf_rd,
  input  logic              tbuf_wr,
  input  logic [2:0]        flag_clr,
  input  logic              rxd_i,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_buf,
  output logic              ren,
  output logic              rir,
  output logic              eir,
  output logic              oe,
  output logic              tx_start
);
  import srx_pkg::*;
  logic busy_q;
  logic start;
  logic sample;
  logic byte_done;
  logic [DATA_W-1:0] next_word;
  logic [2:0] flags;

  assign start = ren_set & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      ren      <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      tx_start <= tbuf_wr & ~busy_q & ~ren_set;
      if (start)          busy_q <= 1'b1;
      else if (byte_done) busy_q <= 1'b0;
      if (byte_done)      ren <= 1'b0;
      else if (ren_set)   ren <= 1'b1;
      else if (ren_clr)   ren <= 1'b0;
    end
  end

  srx_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q),
    .baud_tick(baud_tick), .sclk(sclk_o), .sample(sample)
  );

  srx_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .start(start), .sample(sample), .rxd(rxd_i),
    .byte_done(byte_done), .next_word(next_word)
  );

  srx_flags #(.DATA_W(DATA_W)) u_fl (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .next_word(next_word),
    .buf_rd(buf_rd), .oe_chk_en(oe_chk_en), .flag_clr(flag_clr),
    .rx_buf(rx_buf), .flags(flags)
  );

  assign rir = flags[FL_RIR];
  assign eir = flags[FL_EIR];
  assign oe  = flags[FL_OE];

  assert_ren_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (!ren && sclk_o));
  assert_no_tx_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !tx_start);
  assert_tx_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !$past(tbuf_wr, 1) ) |-> 1'b0);
  assert_clr_keeps_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ren_clr && !byte_done) |=> busy_q);
  assert_set_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ren_set && !byte_done) |=> ($stable(sclk_o) || baud_tick));
endmodule

// File: tb/sim_srx_sync_rx.sv
module sim_srx_sync_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 0, ren_set = 0, ren_clr = 0, oe_chk_en = 0;
  logic buf_rd = 0, tbuf_wr = 0, rxd_i = 0;
  logic [2:0] flag_clr = '0;
  logic sclk_o, ren, rir, eir, oe, tx_start;
  logic [7:0] rx_buf;

  always #2.5 clk = ~clk;

  srx_sync_rx #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .ren_set(ren_set),
    .ren_clr(ren_clr), .oe_chk_en(oe_chk_en), .buf_rd(buf_rd),
    .tbuf_wr(tbuf_wr), .flag_clr(flag_clr), .rxd_i(rxd_i), .sclk_o(sclk_o),
    .rx_buf(rx_buf), .ren(ren), .rir(rir), .eir(eir), .oe(oe),
    .tx_start(tx_start)
  );

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  // ---- reference model (behavioural) ----
  bit m_busy = 0, m_ren = 0, m_phase_low = 0, m_sclk = 1, m_unread = 0;
  bit m_rir = 0, m_eir = 0, m_oe = 0, m_tx = 0;
  int m_buf = 0;
  bit m_q[$];

  always @(posedge clk) begin
    if (rst_n) begin : mdl
      bit fin, ovr;
      int w;
      fin = 0;
      m_tx = tbuf_wr && !m_busy && !ren_set;
      if (m_busy && baud_tick) begin
        if (!m_phase_low) begin m_sclk = 0; m_phase_low = 1; end
        else begin
          m_sclk = 1; m_phase_low = 0; m_q.push_back(rxd_i);
          if (m_q.size() == 8) fin = 1;
        end
      end
      if (ren_clr) m_ren = 0;
      if (ren_set) m_ren = 1;
      if (ren_set && !m_busy) begin
        m_busy = 1; m_phase_low = 0; m_sclk = 1; m_q.delete();
      end
      if (flag_clr[0]) m_rir = 0;
      if (flag_clr[1]) m_eir = 0;
      if (flag_clr[2]) m_oe = 0;
      if (fin) begin
        w = 0;
        foreach (m_q[i]) w = w + (int'(m_q[i]) << i);
        ovr = m_unread && !buf_rd && oe_chk_en;
        m_buf = w; m_busy = 0; m_ren = 0; m_unread = 1; m_rir = 1;
        if (ovr) begin m_eir = 1; m_oe = 1; end
        m_q.delete();
      end else if (buf_rd) m_unread = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(sclk_o == m_sclk, "R2 sclk_o", sclk_o, m_sclk);
    chk(rx_buf == m_buf[7:0], "R3 rx_buf", rx_buf, m_buf);
    chk(ren == m_ren, "R5 ren", ren, m_ren);
    chk(rir == m_rir, "R4 rir", rir, m_rir);
    chk(eir == m_eir, "R7 eir", eir, m_eir);
    chk(oe == m_oe, "R7 oe", oe, m_oe);
    chk(tx_start == m_tx, "R6 tx_start", tx_start, m_tx);
  endtask

  // ---- stimulus helpers ----
  int tick_per = 1;
  int tick_ctr = 0;
  logic [7:0] send_byte = 8'h00;
  bit rd_at_done = 0;
  bit clr_at_done = 0;

  task automatic step();
    compare();
    baud_tick = (tick_ctr % tick_per) == 0;
    tick_ctr++;
    rxd_i = (m_busy && m_q.size() < 8) ? send_byte[m_q.size()] : 1'b0;
    if (m_busy && m_phase_low && baud_tick && m_q.size() == 7) begin
      if (rd_at_done) buf_rd = 1;
      if (clr_at_done) flag_clr = 3'b001;
    end
    @(posedge clk);
    #1;
    ren_set = 0; ren_clr = 0; buf_rd = 0; tbuf_wr = 0; flag_clr = '0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && m_busy; i++) step();
    step();
  endtask

  task automatic start_byte(input logic [7:0] b, input int per);
    send_byte = b; tick_per = per; tick_ctr = 1;
    ren_set = 1;
    step();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclk_o == 1 && ren == 0 && rir == 0 && eir == 0 && oe == 0 &&
        tx_start == 0 && rx_buf == 0, "R1 reset", {rx_buf, sclk_o, ren, rir}, 8'h00 << 3 | 3'b100);
    rst_n = 1;
    @(negedge clk);
    // R2 idle: ticks do not toggle the clock
    tick_per = 1;
    for (int i = 0; i < 6; i++) step();
    chk(sclk_o == 1, "R2 idle clock", sclk_o, 1);

    // R2/R3 basic byte, tick every cycle
    start_byte(8'hA5, 1);
    chk(ren == 1, "R2 ren set", ren, 1);
    step();
    chk(sclk_o == 0, "R2 first tick low", sclk_o, 0);
    wait_idle();
    chk(rx_buf == 8'hA5, "R3 lsb first", rx_buf, 8'hA5);
    chk(rir == 1 && ren == 0, "R4 complete", {rir, ren}, 2'b10);
    for (int i = 0; i < 5; i++) step();
    chk(sclk_o == 1, "R4 clock stopped", sclk_o, 1);
    buf_rd = 1; flag_clr = 3'b001; step();

    // R7 overrun with check enabled, slower ticks
    oe_chk_en = 1;
    start_byte(8'h3C, 3); wait_idle();
    chk(oe == 0, "R7 no ovr when read", oe, 0);
    start_byte(8'hC3, 3); wait_idle();
    chk(oe == 1 && eir == 1, "R7 overrun flags", {oe, eir}, 2'b11);
    chk(rx_buf == 8'hC3, "R7 overwrite", rx_buf, 8'hC3);
    flag_clr = 3'b111; buf_rd = 1; step();
    chk(oe == 0 && eir == 0 && rir == 0, "R9 w1c", {oe, eir, rir}, 0);

    // R7 check disabled
    oe_chk_en = 0;
    start_byte(8'h01, 2); wait_idle();
    start_byte(8'h80, 2); wait_idle();
    chk(oe == 0 && eir == 0, "R7 check off", {oe, eir}, 0);
    chk(rx_buf == 8'h80, "R3 msb last", rx_buf, 8'h80);

    // R8 read in the completion cycle
    oe_chk_en = 1;
    rd_at_done = 1;
    start_byte(8'h5A, 2); wait_idle();
    rd_at_done = 0;
    chk(oe == 0, "R8 read at done", oe, 0);

    // R9 clear in the completion cycle
    flag_clr = 3'b001; step();
    clr_at_done = 1;
    buf_rd = 1; step();
    start_byte(8'h96, 1); wait_idle();
    clr_at_done = 0;
    chk(rir == 1, "R9 set beats clear", rir, 1);

    // R5 clear mid byte
    buf_rd = 1; flag_clr = 3'b111; step();
    start_byte(8'h7E, 2);
    for (int i = 0; i < 5; i++) step();
    ren_clr = 1; step();
    chk(ren == 0, "R5 ren cleared", ren, 0);
    wait_idle();
    chk(rir == 1 && rx_buf == 8'h7E, "R5 byte finished", rx_buf, 8'h7E);

    // R6 transmit write during reception and idle
    buf_rd = 1; flag_clr = 3'b111; step();
    start_byte(8'h42, 2);
    step(); tbuf_wr = 1; step();
    chk(tx_start == 0, "R6 no pulse busy", tx_start, 0);
    // R10 re-arm mid byte
    for (int i = 0; i < 3; i++) step();
    ren_set = 1; step();
    wait_idle();
    chk(rx_buf == 8'h42, "R10 byte unaffected", rx_buf, 8'h42);
    tbuf_wr = 1; step();
    chk(tx_start == 1, "R6 idle pulse", tx_start, 1);
    step();
    chk(tx_start == 0, "R6 pulse one cycle", tx_start, 0);
    tbuf_wr = 1; ren_set = 1; send_byte = 8'hF0; tick_ctr = 1; step();
    chk(tx_start == 0, "R6 write with start", tx_start, 0);
    wait_idle();
    chk(rx_buf == 8'hF0, "R6 byte intact", rx_buf, 8'hF0);
    for (int i = 0; i < 4; i++) step();
    finish_run();
  end
endmodule